// File: doc/BRIEF.md
# DRAM command payload sequencer

This block executes a short program of 32-bit instruction words kept in a small on-chip instruction store. Each timed instruction can place one DRAM command on a simplified command interface: activate, precharge or refresh. It then holds for a cycle count that is encoded in the word itself. A loop instruction sends execution back over a block of earlier words a counted number of times. This makes it possible to produce long, precisely timed activate/precharge/refresh streams from a short program.

A host fills the instruction store through a simple write port and pulses start. It then waits until ready returns to 1. Execution always begins at word 0 and ends once the last word of the store has been executed. Words that are all zero act as one-cycle no-operation padding, so an unused tail of the store costs only one cycle per word.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, ready_o is 1, cmd_valid_o is 0, and every instruction word reads as zero.
- R2: A start_i pulse while ready_o is 1 starts execution at word 0, and ready_o is 0 in the following cycle. A start_i pulse while ready_o is 0 has no effect on the command stream.
- R3: The opcode sits in bits [31:29]. NOOP=0, ACT=1, PRE=2, REF=3 and LOOP=4. Codes 5 to 7 behave as NOOP.
- R4: A non-LOOP instruction occupies T cycles, where T is bits [28:24]. A value of 0 is treated as 1.
- R5: On the first cycle of an ACT, PRE or REF word, cmd_valid_o is 1 for exactly one cycle. In that cycle cmd_op_o carries the opcode, cmd_bank_o carries bits [23:20] and cmd_addr_o carries bits [19:0]. Outside those cycles all four command outputs are 0. A PRE with address bit 10 set therefore reaches the output unchanged, which marks precharge-all.
- R6: LOOP carries a count C in bits [28:16] and a jump J in bits [15:0]. It takes one cycle and issues no command. The J words before it execute C+1 times in total, and then execution falls through.
- R7: The loop counter returns to zero when a loop falls through, so a later LOOP in the same program repeats its own body correctly.
- R8: A LOOP whose jump reaches back further than word 0 returns to word 0.
- R9: When the last word of the store completes, ready_o returns to 1.
- R10: An all-zero word executes as a one-cycle NOOP.
- R11: wr_en_i writes wr_data_i into the word at wr_addr_i on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Instruction store write enable |
| wr_addr_i | input | $clog2(MEM_WORDS) | Word index to write |
| wr_data_i | input | 32 | Instruction word to write |
| start_i | input | 1 | Start pulse |
| ready_o | output | 1 | Idle and ready |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_op_o | output | 3 | Command opcode |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_addr_o | output | ADDR_W | Command row/column address |

## Verification
The bench builds the block with MEM_WORDS set to 16. This keeps the falling-off-the-end termination and the zero-padding tail short, so every program runs to completion and ready returns within a few dozen cycles. With the default address and bank widths, the fields fill the instruction word exactly, so full-width bank and row values and the precharge-all bit can be exercised directly. The small store also lets one program hold two successive loops, which exposes counter reload, and a jump longer than the loop's own position, which exposes the clamp to word 0.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned TS_W    = 5;
  localparam int unsigned CNT_W   = 13;
  localparam int unsigned JUMP_W  = 16;

  typedef enum logic [2:0] {
    OP_NOOP = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRE  = 3'd2,
    OP_REF  = 3'd3,
    OP_LOOP = 3'd4
  } op_e;
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [seq_pkg::WORD_W-1:0]  wdata_i,
  input  logic [AW-1:0]               raddr_i,
  output logic [seq_pkg::WORD_W-1:0]  rdata_o
);
  logic [seq_pkg::WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BANK_W = 4
) (
  input  logic [seq_pkg::WORD_W-1:0]  word_i,
  output seq_pkg::op_e                op_o,
  output logic                        is_loop_o,
  output logic                        is_cmd_o,
  output logic [seq_pkg::TS_W-1:0]    ts_last_o,
  output logic [BANK_W-1:0]           bank_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [seq_pkg::CNT_W-1:0]   count_o,
  output logic [seq_pkg::JUMP_W-1:0]  jump_o
);
  import seq_pkg::*;
  logic [2:0]      raw_op;
  logic [TS_W-1:0] ts;

  assign raw_op = word_i[31:29];
  assign ts     = word_i[28:24];

  always_comb begin
    unique case (raw_op)
      3'd1:    op_o = OP_ACT;
      3'd2:    op_o = OP_PRE;
      3'd3:    op_o = OP_REF;
      3'd4:    op_o = OP_LOOP;
      default: op_o = OP_NOOP;
    endcase
  end

  assign is_loop_o = (op_o == OP_LOOP);
  assign is_cmd_o  = (op_o == OP_ACT) || (op_o == OP_PRE) || (op_o == OP_REF);
  assign ts_last_o = (ts == '0) ? '0 : ts - 1'b1;
  assign addr_o    = word_i[ADDR_W-1:0];
  assign bank_o    = word_i[ADDR_W +: BANK_W];
  assign count_o   = word_i[28:16];
  assign jump_o    = word_i[15:0];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        is_loop_i,
  input  logic [seq_pkg::TS_W-1:0]    ts_last_i,
  input  logic [seq_pkg::CNT_W-1:0]   count_i,
  input  logic [seq_pkg::JUMP_W-1:0]  jump_i,
  output logic [AW-1:0]               pc_o,
  output logic                        busy_o,
  output logic                        first_o
);
  import seq_pkg::*;
  logic                busy_q;
  logic [AW-1:0]       pc_q;
  logic [TS_W-1:0]     slot_q;
  logic [CNT_W-1:0]    iter_q;
  logic [JUMP_W-1:0]   pc_wide;
  logic [AW-1:0]       back_pc;
  logic                at_end;

  assign pc_wide = JUMP_W'(pc_q);
  // jumps past word 0 clamp to word 0
  assign back_pc = (jump_i > pc_wide) ? '0 : AW'(pc_wide - jump_i);
  assign at_end  = (pc_q == AW'(WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      slot_q <= '0;
      iter_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        pc_q   <= '0;
        slot_q <= '0;
        iter_q <= '0;
      end
    end else if (is_loop_i) begin
      if (iter_q == count_i) begin
        iter_q <= '0;
        if (at_end) busy_q <= 1'b0;
        else        pc_q   <= pc_q + 1'b1;
      end else begin
        iter_q <= iter_q + 1'b1;
        pc_q   <= back_pc;
      end
    end else if (slot_q == ts_last_i) begin
      slot_q <= '0;
      if (at_end) busy_q <= 1'b0;
      else        pc_q   <= pc_q + 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign pc_o    = pc_q;
  assign busy_o  = busy_q;
  assign first_o = busy_q && (slot_q == '0);
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq #(
  parameter int unsigned MEM_WORDS = 64,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BANK_W    = 4,
  localparam int unsigned AW = $clog2(MEM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              start_i,
  output logic              ready_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  import seq_pkg::*;

  logic [AW-1:0]     pc;
  logic [WORD_W-1:0] word;
  op_e               op;
  logic              is_loop, is_cmd, busy, first;
  logic [TS_W-1:0]   ts_last;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  count;
  logic [JUMP_W-1:0] jump;

  seq_imem #(.WORDS(MEM_WORDS)) u_imem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i), .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i), .raddr_i(pc), .rdata_o(word)
  );

  seq_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
    .word_i(word), .op_o(op), .is_loop_o(is_loop), .is_cmd_o(is_cmd),
    .ts_last_o(ts_last), .bank_o(bank), .addr_o(addr), .count_o(count),
    .jump_o(jump)
  );

  seq_ctrl #(.WORDS(MEM_WORDS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .is_loop_i(is_loop),
    .ts_last_i(ts_last), .count_i(count), .jump_i(jump), .pc_o(pc),
    .busy_o(busy), .first_o(first)
  );

  assign ready_o     = !busy;
  assign cmd_valid_o = first && is_cmd;
  assign cmd_op_o    = cmd_valid_o ? op   : 3'd0;
  assign cmd_bank_o  = cmd_valid_o ? bank : '0;
  assign cmd_addr_o  = cmd_valid_o ? addr : '0;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_o,
  input logic              cmd_valid_o,
  input logic [2:0]        cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ADDR_W-1:0] cmd_addr_o
);
  AST_NO_CMD_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cmd_valid_o); // R5
  AST_START_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |=> !ready_o); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !start_i |=> ready_o); // R2
  AST_CMD_OP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_op_o == 3'd1 || cmd_op_o == 3'd2 || cmd_op_o == 3'd3)); // R3
  AST_QUIET_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_op_o == 3'd0 && cmd_bank_o == '0 && cmd_addr_o == '0)); // R5
endmodule

bind dram_cmd_seq seq_checker #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_bank_o(cmd_bank_o),
  .cmd_addr_o(cmd_addr_o)
);

// File: tb/sim_dram_cmd_seq.sv
`timescale 1ns/1ps
module sim_dram_cmd_seq;
  localparam int WORDS = 16;
  localparam int AW    = $clog2(WORDS);

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ready, cvalid;
  logic [2:0]  cop;
  logic [3:0]  cbank;
  logic [19:0] caddr;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_cmd_seq #(.MEM_WORDS(WORDS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .ready_o(ready), .cmd_valid_o(cvalid),
    .cmd_op_o(cop), .cmd_bank_o(cbank), .cmd_addr_o(caddr)
  );

  int prog [WORDS];
  int ev_v[$], ev_op[$], ev_bank[$], ev_addr[$];

  function automatic int enc(int op, int ts, int bank, int addr);
    return (op << 29) | (ts << 24) | (bank << 20) | addr;
  endfunction
  function automatic int enc_loop(int cnt, int jmp);
    return (4 << 29) | (cnt << 16) | jmp;
  endfunction

  task automatic check(string tag, int av, int aop, int ab, int aa, int ar,
                       int ev, int eop, int eb, int ea, int er, int cyc);
    checks++;
    if (av != ev || aop != eop || ab != eb || aa != ea || ar != er) begin
      failures++;
      $display("FAIL %s cyc %0d: actual v=%0d op=%0d b=%0d a=%h rdy=%0d expected v=%0d op=%0d b=%0d a=%h rdy=%0d",
               tag, cyc, av, aop, ab, aa, ar, ev, eop, eb, ea, er);
    end
  endtask

  task automatic load(string tag);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = prog[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // behavioural interpretation of the program into a per-cycle trace
  task automatic build_trace();
    int pc = 0, iter = 0, guard = 0;
    ev_v.delete(); ev_op.delete(); ev_bank.delete(); ev_addr.delete();
    while (pc < WORDS && guard < 5000) begin
      int w = prog[pc];
      int op = (w >>> 29) & 7;
      guard++;
      if (op == 4) begin
        int c = (w >>> 16) & 13'h1fff, j = w & 16'hffff;
        ev_v.push_back(0); ev_op.push_back(0); ev_bank.push_back(0); ev_addr.push_back(0);
        if (iter == c) begin iter = 0; pc++; end
        else begin iter++; pc = (j > pc) ? 0 : pc - j; end
      end else begin
        int ts = (w >>> 24) & 31;
        if (ts == 0) ts = 1;
        for (int k = 0; k < ts; k++) begin
          bit cmd = (k == 0) && (op >= 1 && op <= 3);
          ev_v.push_back(cmd);
          ev_op.push_back(cmd ? op : 0);
          ev_bank.push_back(cmd ? ((w >>> 20) & 15) : 0);
          ev_addr.push_back(cmd ? (w & 20'hfffff) : 0);
        end
        pc++;
      end
    end
  endtask

  task automatic run(string tag, int poke_at);
    build_trace();
    @(negedge clk);
    check({tag, " R2 pre-start"}, 0, 0, 0, 0, int'(ready), 0, 0, 0, 0, 1, -1);
    start = 1'b1;
    for (int i = 0; i < ev_v.size(); i++) begin
      @(negedge clk);
      start = (i == poke_at);
      check(tag, int'(cvalid), int'(cop), int'(cbank), int'(caddr), int'(ready),
            ev_v[i], ev_op[i], ev_bank[i], ev_addr[i], 0, i);
    end
    @(negedge clk);
    start = 1'b0;
    check({tag, " R9 end"}, int'(cvalid), 0, 0, 0, int'(ready), 0, 0, 0, 0, 1, ev_v.size());
  endtask

  task automatic clear_prog();
    for (int i = 0; i < WORDS; i++) prog[i] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 in reset", int'(cvalid), int'(cop), int'(cbank), int'(caddr), int'(ready), 0, 0, 0, 0, 1, -1);
    rst_n = 1'b1;
    // R1 R10: store zeroed after reset -> 16 one-cycle NOOPs
    clear_prog();
    run("R1 R10 zero store", -1);

    // R3 R4 R5 R11: plain commands, timeslices, precharge-all bit
    clear_prog();
    prog[0] = enc(1, 3, 9, 20'h0155A);
    prog[1] = enc(2, 2, 0, 20'h00400);
    prog[2] = enc(3, 0, 0, 0);
    prog[3] = enc(0, 4, 0, 0);
    prog[4] = enc(1, 1, 15, 20'hFFFFF);
    prog[5] = enc(1, 1, 1, 20'h00003);
    load("R11");
    run("R3 R4 R5 R11 cmds", -1);

    // R3: codes 5..7 act as timed NOOP
    clear_prog();
    prog[0] = enc(7, 3, 5, 7);
    prog[1] = enc(5, 2, 1, 1);
    prog[2] = enc(6, 0, 0, 0);
    prog[3] = enc(3, 2, 0, 0);
    load("R3");
    run("R3 spare codes", -1);

    // R6 R7: two successive loops share the counter
    clear_prog();
    prog[0] = enc(0, 1, 0, 0);
    prog[1] = enc(1, 2, 3, 20'h00100);
    prog[2] = enc(2, 1, 0, 20'h00400);
    prog[3] = enc_loop(2, 2);
    prog[4] = enc(1, 1, 4, 20'h00200);
    prog[5] = enc_loop(1, 1);
    prog[6] = enc_loop(0, 3);
    prog[7] = enc(3, 3, 0, 0);
    load("R6");
    run("R6 R7 loops", -1);

    // R8: jump beyond word 0 clamps; R2: start while busy ignored
    clear_prog();
    prog[0] = enc(3, 1, 0, 0);
    prog[1] = enc(1, 2, 2, 20'h00077);
    prog[2] = enc_loop(1, 9);
    load("R8");
    run("R8 R2 clamp busy start", 3);

    // R6: loop on the last word of the store
    clear_prog();
    prog[14] = enc(1, 1, 6, 20'h00042);
    prog[15] = enc_loop(3, 1);
    load("R6b");
    run("R6 R9 last word loop", -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule